// File: doc/BRIEF.md
# ADC Result Store with Threshold Hit Flags

This block is the word store that sits between a multi-channel analog-to-digital converter and the system bus. It holds one 12-bit word per channel. The enable input decides what each word means. While the converter is off, software writes a word to program that channel's threshold. While the converter is on, the bus can only read, and every finished conversion overwrites its channel's word.

A compare path can be switched on. When it is, each new conversion is checked against the threshold that its word held just before the overwrite. A match sets a sticky hit flag for that channel. Software reads the hit flags as two 16-bit halves and clears them by writing 1s. The word count is a parameter. It must be even and no larger than 32, and elaboration stops if it is not. The upper hit half has no storage when the count is 16 or less.

Top module: `adc_result_store`

## Requirements
- R1: Bus addresses 0 to NUM_WORDS-1 each select one word. The stored value is 12 bits, read right-justified, and bits 15:12 read as 0. Addresses at or above NUM_WORDS that are not hit registers read as 0.
- R2: While adcEnable is 0, a bus write to a word address stores busWrData[11:0] in that word.
- R3: While adcEnable is 1, bus writes to word addresses have no effect.
- R4: While adcEnable is 1, convValid writes convResult into word convChan. While adcEnable is 0, convValid has no effect.
- R5: Changing adcEnable leaves every word and every hit flag unchanged.
- R6: With cmpMode 00, a conversion sets hit flag convChan when the result is below the word's old value. With 01 it sets the flag when the result is at or above that value, and with 10 when the two are equal. With 11 no flag is set.
- R7: A hit flag stays set until a bus write puts a 1 in its bit position at address 32 (channels 0 to 15) or address 33 (channels 16 to 31). A flag being set in the same cycle as its clear stays set.
- R8: Address 32 reads the flags of channels 0 to 15 in bits 0 to 15. Address 33 reads channels 16 to 31 in bits 0 to 15. Bits for channels at or above NUM_WORDS read as 0.
- R9: When a conversion writes the word the bus is reading, the read shows the old value in that cycle and the new value in the next cycle.
- R10: A conversion with convChan at or above NUM_WORDS, while enabled, changes nothing. It makes convErr 1 for exactly the following cycle.
- R11: After reset, every word, every hit flag and convErr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adcEnable | input | 1 | Converter on: store holds results and the bus is read-only |
| cmpMode | input | 2 | Compare selection: 00 below, 01 at or above, 10 equal, 11 off |
| busAddr | input | 6 | Bus word or hit-register address |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 16 | Bus write data |
| busRdData | output | 16 | Combinational read of the addressed location |
| convValid | input | 1 | Converter result strobe |
| convChan | input | 5 | Channel of the result |
| convResult | input | 12 | Conversion result |
| convErr | output | 1 | One-cycle pulse for an out-of-range channel |

## Verification
The bench builds the block with NUM_WORDS = 20. That count is above 16, so the upper hit half is live, and it is below 32, so the unused channel indices 20 to 31 are reachable. Both the dropped-write error path and the zero readback of flag bits beyond the depth are therefore exercised. A behavioural model compares busRdData and convErr on every cycle. It covers all four compare modes, clears that coincide with sets, and enable toggles with data held in the store.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
  localparam int IDX_W  = 5;
  localparam int BUS_AW = 6;
  localparam int WORD_W = 16;
  localparam logic [BUS_AW-1:0] HIT_LO_ADDR = 6'd32;
  localparam logic [BUS_AW-1:0] HIT_HI_ADDR = 6'd33;

  typedef enum logic [1:0] {
    CMP_BELOW    = 2'b00,
    CMP_AT_ABOVE = 2'b01,
    CMP_EQUAL    = 2'b10,
    CMP_OFF      = 2'b11
  } cmpMode_e;

  typedef struct packed {
    logic             wordWr;
    logic             convWr;
    logic             hitClrLo;
    logic             hitClrHi;
    logic [IDX_W-1:0] busIdx;
    logic [IDX_W-1:0] convIdx;
  } bufStrobes_t;
endpackage

// File: rtl/adcbuf_ctrl.sv
module adcbuf_ctrl
  import adcbuf_pkg::*;
#(
  parameter int NUM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcEnable,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              convValid,
  input  logic [IDX_W-1:0]  convChan,
  output bufStrobes_t       strb,
  output logic              convErr
);
  localparam bit HAS_HI = (NUM_WORDS > 16);
  localparam logic [BUS_AW-1:0] DEPTH = BUS_AW'(NUM_WORDS);

  logic busInRange, convInRange, errNext;

  always_comb begin
    busInRange    = (busAddr < DEPTH);
    convInRange   = ({1'b0, convChan} < DEPTH);
    strb.busIdx   = busAddr[IDX_W-1:0];
    strb.convIdx  = convChan;
    strb.wordWr   = busWrEn && !adcEnable && busInRange;
    strb.convWr   = convValid && adcEnable && convInRange;
    strb.hitClrLo = busWrEn && (busAddr == HIT_LO_ADDR);
    strb.hitClrHi = HAS_HI && busWrEn && (busAddr == HIT_HI_ADDR);
    errNext       = convValid && adcEnable && !convInRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) convErr <= 1'b0;
    else       convErr <= errNext;
  end

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    convErr |-> $past(convValid && adcEnable && (convChan >= NUM_WORDS)));
endmodule

// File: rtl/adcbuf_dp.sv
module adcbuf_dp
  import adcbuf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int RES_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       strb,
  input  logic [1:0]        cmpMode,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  input  logic [RES_W-1:0]  convResult,
  output logic [WORD_W-1:0] busRdData
);
  localparam int FLAG_W = 2 * WORD_W;

  logic [RES_W-1:0]     store [NUM_WORDS];
  logic [NUM_WORDS-1:0] hits, setMask, clrMask;
  logic [FLAG_W-1:0]    hitsWide, clrWide;
  logic [RES_W-1:0]     oldWord;
  logic                 match;

  always_comb begin
    oldWord = store[strb.convIdx];
    unique case (cmpMode_e'(cmpMode))
      CMP_BELOW:    match = convResult <  oldWord;
      CMP_AT_ABOVE: match = convResult >= oldWord;
      CMP_EQUAL:    match = convResult == oldWord;
      default:      match = 1'b0;
    endcase
    setMask = (strb.convWr && match) ? (NUM_WORDS'(1) << strb.convIdx) : '0;
    clrWide = {strb.hitClrHi ? busWrData : '0, strb.hitClrLo ? busWrData : '0};
    clrMask = clrWide[NUM_WORDS-1:0];
    hitsWide = '0;
    hitsWide[NUM_WORDS-1:0] = hits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) store[i] <= '0;
      hits <= '0;
    end else begin
      if (strb.wordWr) store[strb.busIdx]  <= busWrData[RES_W-1:0];
      if (strb.convWr) store[strb.convIdx] <= convResult;
      hits <= (hits & ~clrMask) | setMask;
    end
  end

  always_comb begin
    if (busAddr < BUS_AW'(NUM_WORDS))
      busRdData = WORD_W'(store[busAddr[IDX_W-1:0]]);
    else if (busAddr == HIT_LO_ADDR)
      busRdData = hitsWide[WORD_W-1:0];
    else if (busAddr == HIT_HI_ADDR)
      busRdData = hitsWide[FLAG_W-1:WORD_W];
    else
      busRdData = '0;
  end

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < NUM_WORDS) |-> (busRdData[WORD_W-1:RES_W] == '0));

  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wordWr && !strb.convWr && busAddr < NUM_WORDS) ##1 (busAddr == $past(busAddr))
      |-> $stable(busRdData));

  // R7
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.hitClrLo) && !$past(strb.hitClrHi)) |-> (($past(hits) & ~hits) == '0));
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adcbuf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int RES_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcEnable,
  input  logic [1:0]        cmpMode,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic              convValid,
  input  logic [IDX_W-1:0]  convChan,
  input  logic [RES_W-1:0]  convResult,
  output logic              convErr
);
  if ((NUM_WORDS % 2) != 0 || NUM_WORDS > 32 || NUM_WORDS < 2) begin : gBadDepth
    $error("adc_result_store: NUM_WORDS must be even and within 2..32");
  end

  bufStrobes_t strb;

  adcbuf_ctrl #(.NUM_WORDS(NUM_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable), .busAddr(busAddr),
    .busWrEn(busWrEn), .convValid(convValid), .convChan(convChan),
    .strb(strb), .convErr(convErr)
  );

  adcbuf_dp #(.NUM_WORDS(NUM_WORDS), .RES_W(RES_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpMode(cmpMode), .busAddr(busAddr),
    .busWrData(busWrData), .convResult(convResult), .busRdData(busRdData)
  );
endmodule

// File: tb/adc_result_store_test.sv
`timescale 1ns/1ps
module adc_result_store_test;
  localparam int N = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcEnable = 1'b0;
  logic [1:0]  cmpMode = 2'b11;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        convValid = 1'b0;
  logic [4:0]  convChan = '0;
  logic [11:0] convResult = '0;
  logic        convErr;

  int checks = 0;
  int fails  = 0;

  int unsigned refMem [32];
  logic [31:0] refHits;
  bit          refErr;

  always #2.5 clk = ~clk;

  adc_result_store #(.NUM_WORDS(N)) uut (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable), .cmpMode(cmpMode),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .convValid(convValid), .convChan(convChan),
    .convResult(convResult), .convErr(convErr)
  );

  function automatic logic [15:0] refRead(input logic [5:0] a);
    if (a < N)        return 16'(refMem[a]);
    else if (a == 32) return refHits[15:0];
    else if (a == 33) return refHits[31:16];
    else              return 16'h0;
  endfunction

  task automatic modelStep();
    bit hit;
    int unsigned thr;
    refErr = convValid && adcEnable && (convChan >= N);
    if (busWrEn && !adcEnable && busAddr < N) refMem[busAddr] = busWrData & 16'h0FFF;
    if (busWrEn && busAddr == 32) refHits[15:0] = refHits[15:0] & ~busWrData;
    if (busWrEn && busAddr == 33) refHits[31:16] = refHits[31:16] & ~busWrData;
    if (convValid && adcEnable && convChan < N) begin
      thr = refMem[convChan];
      case (cmpMode)
        2'b00:   hit = convResult < thr;
        2'b01:   hit = convResult >= thr;
        2'b10:   hit = convResult == thr;
        default: hit = 1'b0;
      endcase
      if (hit) refHits[convChan] = 1'b1;
      refMem[convChan] = convResult;
    end
    refHits = refHits & ((32'h1 << N) - 1);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    #1;
    check(tag, busRdData, refRead(busAddr));
    check("R10 convErr", 16'(convErr), 16'(refErr));
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle();
    busWrEn = 0; convValid = 0;
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d, input string tag);
    busAddr = a; busWrData = d; busWrEn = 1; cyc(tag); idle();
  endtask

  task automatic readAt(input logic [5:0] a, input string tag);
    busAddr = a; cyc(tag);
  endtask

  task automatic conv(input logic [4:0] ch, input logic [11:0] r, input string tag);
    convChan = ch; convResult = r; convValid = 1; cyc(tag); idle();
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    foreach (refMem[i]) refMem[i] = 0;
    refHits = '0; refErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    readAt(0, "R11 word0"); readAt(19, "R11 word19");
    readAt(32, "R11 hitLo"); readAt(33, "R11 hitHi");
    // R2 threshold programming, high bits dropped (R1)
    for (int i = 0; i < N; i++) busWrite(6'(i), 16'hF000 | 16'(i * 200 + 50), "R2 write");
    for (int i = 0; i < N; i++) readAt(6'(i), "R2 readback R1");
    readAt(20, "R1 beyond depth"); readAt(40, "R1 unused addr");
    // R4 conversions ignored while disabled
    conv(3, 12'd7, "R4 disabled conv"); readAt(3, "R4 word3 kept");
    // R5 enable keeps contents
    adcEnable = 1; readAt(5, "R5 after enable"); readAt(32, "R5 hits after enable");
    // R3 bus writes locked out
    busWrite(2, 16'h0123, "R3 locked write"); readAt(2, "R3 word2 kept");
    // R6 compare modes
    cmpMode = 2'b00;
    conv(1, 12'd249, "R6 below hit"); conv(0, 12'd60, "R6 below miss");
    readAt(32, "R6 hit ch1"); readAt(1, "R4 result stored");
    cmpMode = 2'b01;
    conv(2, 12'd450, "R6 at-or-above hit"); conv(9, 12'd1, "R6 at-or-above miss");
    cmpMode = 2'b10;
    conv(4, 12'd850, "R6 equal hit"); conv(5, 12'd1, "R6 equal miss");
    cmpMode = 2'b11;
    conv(6, 12'd0, "R6 off"); readAt(32, "R6 hit pattern");
    cmpMode = 2'b00;
    conv(17, 12'd10, "R8 high channel"); readAt(33, "R8 high half");
    // R9 same-cycle read and conversion write
    busAddr = 7; convChan = 7; convResult = 12'hABC; convValid = 1;
    cyc("R9 old value"); idle(); cyc("R9 new value");
    // R7 clears
    busWrite(32, 16'h0002, "R7 clear ch1"); readAt(32, "R7 after clear");
    busWrite(33, 16'hFFFF, "R7 clear high"); readAt(33, "R7 high cleared");
    cmpMode = 2'b10;
    busAddr = 32; busWrData = 16'h0010; busWrEn = 1;
    convChan = 4; convResult = 12'd850; convValid = 1;
    cyc("R7 set vs clear"); idle(); readAt(32, "R7 set wins");
    readAt(30, "R1 high addr");
    // R10 out-of-range channels
    conv(25, 12'd5, "R10 bad channel"); readAt(32, "R10 pulse");
    readAt(33, "R10 nothing changed");
    convChan = 31; convValid = 1; cyc("R10 back to back"); cyc("R10 back to back");
    idle(); cyc("R10 pulse end"); cyc("R10 idle");
    conv(19, 12'd3, "R10 valid last ch"); readAt(19, "R4 last ch stored");
    // R5 disable keeps, writes reopen
    adcEnable = 0; readAt(7, "R5 after disable"); readAt(32, "R5 hits after disable");
    busWrite(8, 16'h0FFF, "R2 rewrite"); readAt(8, "R2 rewrite read");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule